// File: doc/BRIEF.md
# Flash Erase and Program Timing Sequencer

This block runs the timed operations of an embedded NOR flash macro: page erase, whole-array erase, reference-cell erase, programming of up to one row of buffered bytes, and trim-code recall. Software loads an address and fills a small byte buffer, then sets one bit of the operation word to start an operation. The block then holds `busy` high. It walks the macro through a setup phase, a main pulse and a high-voltage hold phase. Each phase lasts a number of clock cycles taken from fields of three timing words.

When the hold phase ends, the block clears `busy` and gives a one-cycle `done`. It drops the operation bit and moves the address forward by the number of buffered bytes, so that back-to-back program operations need only one address load. The timing words, the address and the buffer are written over plain strobe ports. Register decode, write protection and the analog array sit outside this block, and the array is seen only through the strobe outputs.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `op_q`, `addr_q` and `pb_idx` are all 0.
- R2: A write to the operation word (`op_we`) while idle, with at least one bit set, raises `busy` in the next cycle. In that cycle `op_q` shows the one chosen operation as a single bit: bit 0 erases the whole array, bit 1 erases one page, bit 2 programs, bit 3 erases the reference cell, bit 4 recalls the trim code. A write of all zeros starts nothing.
- R3: When several bits are written together, the lowest-numbered set bit wins, which gives the order whole array, page, program, reference cell, recall.
- R4: An operation runs through setup, then the main pulse, then hold, with exactly one of `fl_setup`, `fl_pulse` and `fl_hold` high in each busy cycle.
  - Setup lasts `timing2[27:24]` cycles.
  - The main pulse lasts `timing1[23:0]` cycles for the three erase kinds, `timing2[15:0]` cycles for program, and `timing2[23:16]` cycles for recall.
  - Hold lasts `timing0[31:16]` cycles.
  - A count of zero lasts one cycle.
  - `busy` is high for the sum of the three phases.
- R5: `done` is high for exactly one cycle: the first cycle in which `busy` is low again. In that same cycle `op_q` reads 0, and it is 0 again in the cycle after.
- R6: A write to the operation word while `busy` is high is ignored. It changes neither the running operation nor its length.
- R7: Each buffer data write (`pb_we`) stores the byte at the current index, and the index then increments. The index stops at 32, and further data writes are dropped. `pb_clr` sets the index to 0.
- R8: In the `done` cycle, `addr_q` equals its previous value plus the buffer index, wrapping at the address width. The index itself is left unchanged.
- R9: During a program operation, `fl_ben` enables byte lanes `a` to `a+n-1` of the 32-byte row, where `a` is `addr_q[4:0]` and `n` is the index. Lanes past lane 31 are dropped. Lane `a+k` of `fl_wdata` carries buffer byte `k`. All other lanes have enable 0 and data 0, and both outputs are all zero for every other operation.
- R10: While busy, `fl_addr` shows `addr_q` with bits [11:0] cleared for a page erase, `addr_q` with bits [4:0] cleared for program, and `addr_q` unchanged for the other operations.
- R11: While `busy` is high, address loads, buffer data writes and index clears are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_we | input | 1 | Operation word write strobe |
| op_wdata | input | 5 | Operation bits to write |
| addr_we | input | 1 | Address load strobe |
| addr_wdata | input | 20 | Address to load |
| pb_we | input | 1 | Buffer data write strobe |
| pb_wdata | input | 8 | Buffer data byte |
| pb_clr | input | 1 | Clear buffer index |
| timing0 | input | 32 | Read wait states [5:0], hold count [31:16] |
| timing1 | input | 32 | Erase pulse count [23:0] |
| timing2 | input | 32 | Program count [15:0], recall count [23:16], setup count [27:24] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion flag |
| op_q | output | 5 | Running operation, one-hot, self-clearing |
| addr_q | output | 20 | Address register |
| pb_idx | output | 6 | Buffer index |
| fl_rd_wait | output | 6 | Read wait states for the macro |
| fl_addr | output | 20 | Address presented to the macro |
| fl_setup | output | 1 | Setup phase strobe |
| fl_pulse | output | 1 | Main pulse strobe |
| fl_hold | output | 1 | Hold phase strobe |
| fl_ben | output | 32 | Program byte-lane enables |
| fl_wdata | output | 256 | Program row data |

## Verification
An operation write sampled at one clock edge shows up as `busy` and `op_q` just after that edge. The phase strobes follow one per cycle, and `done` arrives together with the advanced address and the cleared `op_q` in the first cycle after the last hold cycle. A buffer write or index clear shows in `pb_idx` one cycle after it is sampled. The bench drives every input on the falling edge and samples every output on a later falling edge. It counts busy cycles and phase strobes one per falling edge, so each expected count is the plain sum of the programmed phase lengths. It captures lane enables, data and address from the first main-pulse cycle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_MAIN  = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;

   localparam int OP_N      = 5;
   localparam int OP_MASS   = 0;
   localparam int OP_PAGE   = 1;
   localparam int OP_PROG   = 2;
   localparam int OP_REF    = 3;
   localparam int OP_RECALL = 4;

   // timing field positions
   localparam int T0_WAIT_LO  = 0;
   localparam int T0_WAIT_W   = 6;
   localparam int T0_HOLD_LO  = 16;
   localparam int T0_HOLD_W   = 16;
   localparam int T1_ERASE_LO = 0;
   localparam int T1_ERASE_W  = 24;
   localparam int T2_PROG_LO  = 0;
   localparam int T2_PROG_W   = 16;
   localparam int T2_REC_LO   = 16;
   localparam int T2_REC_W    = 8;
   localparam int T2_SET_LO   = 24;
   localparam int T2_SET_W    = 4;

endpackage

// File: rtl/flash_op_prio.sv
module flash_op_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign seen[i+1] = seen[i] | req[i];
      assign grant[i]  = req[i] & ~seen[i];
   end
endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer
   import flash_seq_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0] main_cnt,
   input  logic [CNT_W-1:0] hold_cnt,
   output phase_e           phase,
   output logic             last,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] x);
      return (x == '0) ? '0 : x - 1'b1;
   endfunction

   assign last = (phase == PH_HOLD) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_SETUP;
                  cnt   <= len_m1(setup_cnt);
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  phase <= PH_MAIN;
                  cnt   <= len_m1(main_cnt);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_MAIN: begin
               if (cnt == '0) begin
                  phase <= PH_HOLD;
                  cnt   <= len_m1(hold_cnt);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt == '0) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_prog_buf.sv
module flash_prog_buf #(
   parameter int PB_BYTES = 32,
   localparam int OFF_W = $clog2(PB_BYTES),
   localparam int IDX_W = OFF_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_byte,
   input  logic                  clr,
   input  logic [OFF_W-1:0]      off,
   output logic [IDX_W-1:0]      idx,
   output logic [PB_BYTES-1:0]   ben,
   output logic [PB_BYTES*8-1:0] wdata
);
   logic [7:0] mem [PB_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (wr_en && (idx < IDX_W'(PB_BYTES))) begin
         idx <= idx + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!clr && wr_en && (idx < IDX_W'(PB_BYTES)))
         mem[idx[OFF_W-1:0]] <= wr_byte;
   end

   for (genvar j = 0; j < PB_BYTES; j++) begin : g_lane
      logic [IDX_W-1:0] rel;
      logic             hit;
      assign rel = IDX_W'(j) - {1'b0, off};
      assign hit = (IDX_W'(j) >= {1'b0, off}) && (rel < idx);
      assign ben[j] = hit;
      assign wdata[j*8 +: 8] = hit ? mem[rel[OFF_W-1:0]] : 8'h00;
   end
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int PB_BYTES   = 32,
   parameter int PAGE_BYTES = 4096,
   parameter int CNT_W      = 24,
   localparam int OFF_W = $clog2(PB_BYTES),
   localparam int IDX_W = OFF_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_we,
   input  logic [OP_N-1:0]       op_wdata,
   input  logic                  addr_we,
   input  logic [ADDR_W-1:0]     addr_wdata,
   input  logic                  pb_we,
   input  logic [7:0]            pb_wdata,
   input  logic                  pb_clr,
   input  logic [31:0]           timing0,
   input  logic [31:0]           timing1,
   input  logic [31:0]           timing2,
   output logic                  busy,
   output logic                  done,
   output logic [OP_N-1:0]       op_q,
   output logic [ADDR_W-1:0]     addr_q,
   output logic [IDX_W-1:0]      pb_idx,
   output logic [5:0]            fl_rd_wait,
   output logic [ADDR_W-1:0]     fl_addr,
   output logic                  fl_setup,
   output logic                  fl_pulse,
   output logic                  fl_hold,
   output logic [PB_BYTES-1:0]   fl_ben,
   output logic [PB_BYTES*8-1:0] fl_wdata
);
   localparam logic [ADDR_W-1:0] PAGE_MASK = ~(ADDR_W'(PAGE_BYTES - 1));
   localparam logic [ADDR_W-1:0] ROW_MASK  = ~(ADDR_W'(PB_BYTES - 1));

   if (CNT_W < T1_ERASE_W) begin : g_bad_cnt
      $error("CNT_W must hold the widest timing field");
   end
   if ((1 << OFF_W) != PB_BYTES) begin : g_bad_pb
      $error("PB_BYTES must be a power of two");
   end
   if ((PAGE_BYTES < PB_BYTES) || (ADDR_W <= $clog2(PAGE_BYTES))) begin : g_bad_page
      $error("page size must exceed the row and fit the address");
   end

   phase_e           phase;
   logic             last;
   logic             start;
   logic [OP_N-1:0]  grant;
   logic [CNT_W-1:0] setup_cnt, main_cnt, hold_cnt;
   logic [PB_BYTES-1:0]   raw_ben;
   logic [PB_BYTES*8-1:0] raw_wdata;

   assign busy  = (phase != PH_IDLE);
   assign start = op_we && !busy && (|op_wdata);

   flash_op_prio #(.N(OP_N)) u_prio (
      .req   (op_wdata),
      .grant (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         op_q <= '0;
      else if (start)
         op_q <= grant;
      else if (last)
         op_q <= '0;
   end

   always_comb begin
      setup_cnt = CNT_W'(timing2[T2_SET_LO +: T2_SET_W]);
      hold_cnt  = CNT_W'(timing0[T0_HOLD_LO +: T0_HOLD_W]);
      if (op_q[OP_PROG])
         main_cnt = CNT_W'(timing2[T2_PROG_LO +: T2_PROG_W]);
      else if (op_q[OP_RECALL])
         main_cnt = CNT_W'(timing2[T2_REC_LO +: T2_REC_W]);
      else
         main_cnt = CNT_W'(timing1[T1_ERASE_LO +: T1_ERASE_W]);
   end

   flash_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .setup_cnt (setup_cnt),
      .main_cnt  (main_cnt),
      .hold_cnt  (hold_cnt),
      .phase     (phase),
      .last      (last),
      .done      (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (last)
         addr_q <= addr_q + ADDR_W'(pb_idx);
      else if (addr_we && !busy)
         addr_q <= addr_wdata;
   end

   flash_prog_buf #(.PB_BYTES(PB_BYTES)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pb_we && !busy),
      .wr_byte (pb_wdata),
      .clr     (pb_clr && !busy),
      .off     (addr_q[OFF_W-1:0]),
      .idx     (pb_idx),
      .ben     (raw_ben),
      .wdata   (raw_wdata)
   );

   always_comb begin
      if (op_q[OP_PAGE])
         fl_addr = addr_q & PAGE_MASK;
      else if (op_q[OP_PROG])
         fl_addr = addr_q & ROW_MASK;
      else
         fl_addr = addr_q;
   end

   assign fl_ben     = op_q[OP_PROG] ? raw_ben   : '0;
   assign fl_wdata   = op_q[OP_PROG] ? raw_wdata : '0;
   assign fl_setup   = (phase == PH_SETUP);
   assign fl_pulse   = (phase == PH_MAIN);
   assign fl_hold    = (phase == PH_HOLD);
   assign fl_rd_wait = timing0[T0_WAIT_LO +: T0_WAIT_W];
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
   parameter int ADDR_W   = 20,
   parameter int PB_BYTES = 32,
   parameter int IDX_W    = 6,
   parameter int OP_N     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_we,
   input logic              busy,
   input logic              done,
   input logic [OP_N-1:0]   op_q,
   input logic [ADDR_W-1:0] addr_q,
   input logic [IDX_W-1:0]  pb_idx,
   input logic              fl_setup,
   input logic              fl_pulse,
   input logic              fl_hold
);
   a_r2_start_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(op_we));
   a_r2_op_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_q));
   a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones({fl_setup, fl_pulse, fl_hold}) == 1));
   a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(fl_setup || fl_pulse || fl_hold));
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy) && (op_q == '0)));
   a_r6_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(op_q));
   a_r7_idx_limit: assert property (@(posedge clk) disable iff (!rst_n)
      pb_idx <= IDX_W'(PB_BYTES));
   a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (addr_q == ($past(addr_q) + ADDR_W'($past(pb_idx)))));
   a_r11_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> ($stable(addr_q) && $stable(pb_idx)));
endmodule

bind flash_op_sequencer flash_seq_chk #(
   .ADDR_W   (ADDR_W),
   .PB_BYTES (PB_BYTES),
   .IDX_W    (IDX_W),
   .OP_N     (flash_seq_pkg::OP_N)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_we    (op_we),
   .busy     (busy),
   .done     (done),
   .op_q     (op_q),
   .addr_q   (addr_q),
   .pb_idx   (pb_idx),
   .fl_setup (fl_setup),
   .fl_pulse (fl_pulse),
   .fl_hold  (fl_hold)
);

// File: tb/tb_flash_op_sequencer.sv
`timescale 1ns/1ps
module tb_flash_op_sequencer;
   localparam int AW = 20;
   localparam int PB = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, op_we, addr_we, pb_we, pb_clr;
   logic [4:0] op_wdata;
   logic [AW-1:0] addr_wdata;
   logic [7:0] pb_wdata;
   logic [31:0] timing0, timing1, timing2;
   logic busy, done, fl_setup, fl_pulse, fl_hold;
   logic [4:0] op_q;
   logic [AW-1:0] addr_q, fl_addr;
   logic [5:0] pb_idx, fl_rd_wait;
   logic [PB-1:0] fl_ben;
   logic [PB*8-1:0] fl_wdata;

   flash_op_sequencer dut (.*);

   int n_run = 0, n_fail = 0;
   logic [7:0] buf_m [PB];
   int idx_m = 0;
   logic [AW-1:0] addr_m = '0;
   int ts, te, tp, tr, th;

   task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int eff(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic logic [PB-1:0] exp_ben(input int off, input int n);
      logic [PB-1:0] r = '0;
      for (int j = 0; j < PB; j++) if (j >= off && j - off < n) r[j] = 1'b1;
      return r;
   endfunction

   function automatic logic [PB*8-1:0] exp_wd(input int off, input int n);
      logic [PB*8-1:0] r = '0;
      for (int j = 0; j < PB; j++) if (j >= off && j - off < n) r[j*8 +: 8] = buf_m[j-off];
      return r;
   endfunction

   task automatic set_tim(input int s, input int e, input int p, input int rc, input int h);
      ts = s; te = e; tp = p; tr = rc; th = h;
      timing0 = {16'(h), 10'd0, 6'd3};
      timing1 = {8'd0, 24'(e)};
      timing2 = {4'd0, 4'(s), 8'(rc), 16'(p)};
   endtask

   task automatic load_addr(input logic [AW-1:0] a);
      @(negedge clk); addr_we = 1'b1; addr_wdata = a;
      @(negedge clk); addr_we = 1'b0;
      addr_m = a;
   endtask

   task automatic clr_idx();
      @(negedge clk); pb_clr = 1'b1;
      @(negedge clk); pb_clr = 1'b0;
      idx_m = 0;
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk); pb_we = 1'b1; pb_wdata = b;
      @(negedge clk); pb_we = 1'b0;
      if (idx_m < PB) begin buf_m[idx_m] = b; idx_m++; end
   endtask

   // start an operation; poke=1 tries writes during busy (R6, R11)
   task automatic run_op(input logic [4:0] bits, input logic [4:0] want, input bit poke, input string tag);
      int exp_cyc, cyc, cs, cp, ch, main;
      bit cap;
      logic [PB-1:0] c_ben;
      logic [PB*8-1:0] c_wd;
      logic [AW-1:0] c_addr, exp_fa;
      main = want[2] ? tp : (want[4] ? tr : te);
      exp_cyc = eff(ts) + eff(main) + eff(th);
      @(negedge clk); op_we = 1'b1; op_wdata = bits;
      @(negedge clk); op_we = 1'b0;
      check(busy === 1'b1, {tag, " R2 busy after write"}, busy, 1);
      check(op_q === want, {tag, " R2/R3 selected op"}, op_q, want);
      cyc = 1; cs = 0; cp = 0; ch = 0; cap = 0;
      c_ben = '0; c_wd = '0; c_addr = '0;
      forever begin
         if (fl_setup) cs++;
         if (fl_pulse) cp++;
         if (fl_hold) ch++;
         if (fl_setup && (cp + ch) != 0) check(0, {tag, " R4 setup after pulse"}, 0, 1);
         if (fl_pulse && ch != 0) check(0, {tag, " R4 pulse after hold"}, 0, 1);
         if (fl_pulse && !cap) begin cap = 1; c_ben = fl_ben; c_wd = fl_wdata; c_addr = fl_addr; end
         if (poke && cyc == 1) begin
            op_we = 1'b1; op_wdata = 5'b00001;
            addr_we = 1'b1; addr_wdata = ~addr_m;
            pb_we = 1'b1; pb_wdata = 8'h5A;
         end
         @(negedge clk);
         op_we = 1'b0; addr_we = 1'b0; pb_we = 1'b0;
         if (poke && cyc == 1)
            check(op_q === want, {tag, " R6 op unchanged by busy write"}, op_q, want);
         if (!busy || cyc > 4000) break;
         cyc++;
      end
      check(cyc == exp_cyc, {tag, " R4 busy length"}, cyc, exp_cyc);
      check(cs == eff(ts), {tag, " R4 setup length"}, cs, eff(ts));
      check(cp == eff(main), {tag, " R4 pulse length"}, cp, eff(main));
      check(ch == eff(th), {tag, " R4 hold length"}, ch, eff(th));
      check(done === 1'b1, {tag, " R5 done at end"}, done, 1);
      check(op_q === 5'd0, {tag, " R5 op cleared"}, op_q, 0);
      check(addr_q === AW'(addr_m + AW'(idx_m)), {tag, " R8/R11 address advance"}, addr_q, AW'(addr_m + AW'(idx_m)));
      check(pb_idx === 6'(idx_m), {tag, " R8/R11 index kept"}, pb_idx, idx_m);
      exp_fa = want[1] ? (addr_m & ~AW'(4095)) : (want[2] ? (addr_m & ~AW'(31)) : addr_m);
      check(c_addr === exp_fa, {tag, " R10 flash address"}, c_addr, exp_fa);
      if (want[2]) begin
         check(c_ben === exp_ben(int'(addr_m[4:0]), idx_m), {tag, " R9 lane enables"}, c_ben, exp_ben(int'(addr_m[4:0]), idx_m));
         check(c_wd === exp_wd(int'(addr_m[4:0]), idx_m), {tag, " R9 row data"}, c_wd, exp_wd(int'(addr_m[4:0]), idx_m));
      end else begin
         check(c_ben === '0 && c_wd === '0, {tag, " R9 no lanes off program"}, c_ben, 0);
      end
      addr_m = AW'(addr_m + AW'(idx_m));
      @(negedge clk);
      check(done === 1'b0, {tag, " R5 done one cycle"}, done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; op_we = 0; op_wdata = 0; addr_we = 0; addr_wdata = 0;
      pb_we = 0; pb_wdata = 0; pb_clr = 0;
      set_tim(2, 5, 4, 3, 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 0 && done === 0, "R1 busy/done reset", {busy, done}, 0);
      check(op_q === 0, "R1 op reset", op_q, 0);
      check(addr_q === 0 && pb_idx === 0, "R1 addr/idx reset", {addr_q, pb_idx}, 0);
      check(fl_rd_wait === 6'd3, "R4 wait-state field", fl_rd_wait, 3);

      // zero-bit write starts nothing (R2)
      @(negedge clk); op_we = 1'b1; op_wdata = 5'b0;
      @(negedge clk); op_we = 1'b0;
      check(busy === 1'b0, "R2 empty write ignored", busy, 0);

      load_addr(20'h12345);
      run_op(5'b00010, 5'b00010, 0, "page");
      load_addr(20'h00000);
      run_op(5'b00011, 5'b00001, 0, "mass-prio");
      run_op(5'b11000, 5'b01000, 0, "ref-prio");
      run_op(5'b10000, 5'b10000, 0, "recall");
      set_tim(0, 0, 0, 0, 0);
      run_op(5'b01000, 5'b01000, 0, "zero-counts");

      // program with priority over ref/recall, and writes during busy
      set_tim(1, 6, 3, 2, 2);
      load_addr(20'h00104);
      clr_idx();
      for (int k = 0; k < 5; k++) push(8'(8'h10 + k));
      check(pb_idx === 6'd5, "R7 index counts writes", pb_idx, 5);
      run_op(5'b11100, 5'b00100, 1, "prog-poke");

      // saturation and clear (R7)
      clr_idx();
      check(pb_idx === 6'd0, "R7 index clear", pb_idx, 0);
      for (int k = 0; k < 34; k++) push(8'(k * 7 + 1));
      check(pb_idx === 6'd32, "R7 index saturates", pb_idx, 32);
      load_addr(20'h00200);
      run_op(5'b00100, 5'b00100, 0, "prog-full");

      // row clip (R9)
      clr_idx();
      for (int k = 0; k < 8; k++) push(8'(8'hA0 + k));
      load_addr(20'h0031C);
      run_op(5'b00100, 5'b00100, 0, "prog-clip");

      // random program and erase mix
      for (int it = 0; it < 24; it++) begin
         int n;
         set_tim(int'($urandom_range(0, 3)), int'($urandom_range(0, 6)),
                 int'($urandom_range(0, 6)), int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
         load_addr(AW'($urandom));
         clr_idx();
         n = int'($urandom_range(0, 34));
         for (int k = 0; k < n; k++) push(8'($urandom));
         if (it % 4 == 3)
            run_op(5'b00010, 5'b00010, it % 8 == 7, "rand-page");
         else
            run_op(5'b00100, 5'b00100, it % 5 == 0, "rand-prog");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule